// File: doc/BRIEF.md
# Bus I/O Window Address Translator

This block sits between a processor bus and a legacy I/O port bus. Each bus request that falls inside an 8 MB window starting at 0x80000000 becomes a single port cycle. The block picks the port address from the bus address using one of two maps. The flat map keeps the low 16 address bits. The sparse map gathers one 32-byte group from each 4 KB page into a dense port range. Requests outside the window, and requests with an illegal size code, produce no port cycle and raise a one-cycle miss pulse instead.

Port devices expect little-endian byte order, while the host may be big-endian. A parameter selects big-endian host behaviour. When it is set, halfword data has its two bytes exchanged and word data has its four bytes reversed. This applies to write data on the way out and to read data on the way back. Byte data is never reordered. Data bits above the access size are driven as zero.

The block registers each translated request and presents it on the port side one clock after the request. A read returns data one clock after its port read strobe, together with a valid pulse. A new request may be accepted on every clock.

Top module: `io_window_xlate`

## Requirements
- R1: After reset, port_wr, port_rd, bus_miss and bus_rvalid are all low.
- R2: A request with bus_req high, an address in 0x80000000..0x807FFFFF and a legal size produces exactly one strobe one clock later, lasting one clock: port_wr for a write (bus_we=1) or port_rd for a read. A request outside that range produces no strobe and a bus_miss pulse one clock later. A clock without a request produces neither a strobe nor a miss.
- R3: With map_sparse=0, port_addr equals bus address bits [15:0].
- R4: With map_sparse=1, port_addr[15:5] equals bus address bits [22:12] and port_addr[4:0] equals bus address bits [4:0]. Bus address bits [11:5] have no effect on port_addr.
- R5: Size code 0 (byte) drives port_wdata as {24'h0, bus_wdata[7:0]}, and returns read data as {24'h0, port_rdata[7:0]}, at any endianness.
- R6: Size code 1 (halfword) on a big-endian host drives port_wdata as {16'h0, bus_wdata[7:0], bus_wdata[15:8]}. The same exchange is applied to read data.
- R7: Size code 2 (word) on a big-endian host drives port_wdata with the four bytes of bus_wdata in reverse order. The same reversal is applied to read data.
- R8: bus_rvalid pulses one clock after each port_rd strobe and at no other time. With it, bus_rdata carries port_rdata as sampled during the strobe clock, reordered according to the size of that read.
- R9: Size code 3 is illegal. Such a request produces no strobe and a bus_miss pulse, even inside the window.
- R10: With BIG_ENDIAN=0, halfword data passes through as {16'h0, data[15:0]} and word data passes through unchanged, in both directions.
- R11: port_size carries the size code of the request that produced the current strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Request valid this clock |
| bus_addr | input | 32 | Bus byte address |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 illegal |
| bus_we | input | 1 | 1 write, 0 read |
| bus_wdata | input | 32 | Write data in host byte order |
| map_sparse | input | 1 | 0 flat map, 1 sparse map |
| bus_miss | output | 1 | One-clock pulse for an untranslated request |
| bus_rvalid | output | 1 | Read data valid pulse |
| bus_rdata | output | 32 | Read data in host byte order |
| port_addr | output | 16 | Port address |
| port_size | output | 2 | Size code of the current port cycle |
| port_wdata | output | 32 | Write data in port byte order |
| port_wr | output | 1 | Port write strobe |
| port_rd | output | 1 | Port read strobe |
| port_rdata | input | 32 | Port read data, valid while port_rd is high |

## Verification
The assertions assume that the port side presents its read data during the same clock as port_rd, and that map_sparse and the request fields are stable around the sampling edge. The bench's device model drives port_rdata as a function of port_addr only while port_rd is high. All request fields change only on the falling clock edge. The sparse-map address check and the swap checks compare against the previous cycle's inputs, so the bench also issues requests back to back, with no idle clock between them.

// File: rtl/io_xlate_pkg.sv
package io_xlate_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    // legal size codes are the ones below the reserved code
    function automatic logic size_legal(input logic [1:0] sz);
        return acc_size_e'(sz) != SZ_BAD;
    endfunction

endpackage

// File: rtl/io_win_decode.sv
module io_win_decode #(
    parameter int                ADDR_W     = 32,
    parameter int                PORT_W     = 16,
    parameter int                WIN_BITS   = 23,
    parameter int                GROUP_BITS = 5,
    parameter int                PAGE_BIT   = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h8000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              sparse,
    output logic              hit,
    output logic [PORT_W-1:0] port_addr
);

    localparam int PAGE_FIELD_W = WIN_BITS - PAGE_BIT;
    localparam int SPARSE_W     = PAGE_FIELD_W + GROUP_BITS;

    logic [PORT_W-1:0]   flat_addr;
    logic [SPARSE_W-1:0] sparse_raw;
    logic [PORT_W-1:0]   sparse_addr;

    // window hit: upper bits equal the base
    assign hit = (addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);

    assign flat_addr = addr[PORT_W-1:0];

    // page number lands directly above the group offset
    assign sparse_raw = {addr[WIN_BITS-1:PAGE_BIT], addr[GROUP_BITS-1:0]};

    generate
        if (SPARSE_W >= PORT_W) begin : g_sparse_trunc
            assign sparse_addr = sparse_raw[PORT_W-1:0];
        end else begin : g_sparse_ext
            assign sparse_addr = {{(PORT_W-SPARSE_W){1'b0}}, sparse_raw};
        end
    endgenerate

    assign port_addr = sparse ? sparse_addr : flat_addr;

endmodule

// File: rtl/io_lane_swap.sv
module io_lane_swap #(
    parameter int DATA_W     = 32,
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] dout
);

    localparam int LANES = DATA_W / 8;
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;

    logic [7:0]  lane_in  [LANES];
    logic [LW:0] n_bytes;

    // number of active byte lanes for this size, clipped to the bus width
    always_comb begin
        case (size)
            2'd0:    n_bytes = (LW+1)'(1);
            2'd1:    n_bytes = (LANES >= 2) ? (LW+1)'(2) : (LW+1)'(LANES);
            default: n_bytes = (LANES >= 4) ? (LW+1)'(4) : (LW+1)'(LANES);
        endcase
    end

    genvar i;
    generate
        for (i = 0; i < LANES; i++) begin : g_lane
            logic [LW-1:0] sel;
            logic          active;

            assign lane_in[i] = din[i*8 +: 8];
            assign active     = ((LW+1)'(i) < n_bytes);

            always_comb begin
                if (BIG_ENDIAN) begin
                    sel = LW'(n_bytes - (LW+1)'(1) - (LW+1)'(i));
                end else begin
                    sel = LW'(i);
                end
            end

            assign dout[i*8 +: 8] = active ? lane_in[sel] : 8'h00;
        end
    endgenerate

endmodule

// File: rtl/io_window_xlate.sv
module io_window_xlate #(
    parameter int                ADDR_W     = 32,
    parameter int                DATA_W     = 32,
    parameter int                PORT_W     = 16,
    parameter int                WIN_BITS   = 23,
    parameter int                GROUP_BITS = 5,
    parameter int                PAGE_BIT   = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h8000_0000,
    parameter bit                BIG_ENDIAN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              map_sparse,
    output logic              bus_miss,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [PORT_W-1:0] port_addr,
    output logic [1:0]        port_size,
    output logic [DATA_W-1:0] port_wdata,
    output logic              port_wr,
    output logic              port_rd,
    input  logic [DATA_W-1:0] port_rdata
);

    import io_xlate_pkg::*;

    typedef struct packed {
        logic [PORT_W-1:0] port_addr;
        logic [1:0]        port_size;
        logic [DATA_W-1:0] port_wdata;
        logic              port_wr;
        logic              port_rd;
        logic              miss;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } xl_state_t;

    xl_state_t d, q;

    logic              win_hit;
    logic [PORT_W-1:0] xl_addr;
    logic [DATA_W-1:0] wr_swapped;
    logic [DATA_W-1:0] rd_swapped;
    logic              accept;

    io_win_decode #(
        .ADDR_W     (ADDR_W),
        .PORT_W     (PORT_W),
        .WIN_BITS   (WIN_BITS),
        .GROUP_BITS (GROUP_BITS),
        .PAGE_BIT   (PAGE_BIT),
        .WIN_BASE   (WIN_BASE)
    ) u_decode (
        .addr      (bus_addr),
        .sparse    (map_sparse),
        .hit       (win_hit),
        .port_addr (xl_addr)
    );

    // outbound lanes follow the size of the incoming request
    io_lane_swap #(
        .DATA_W     (DATA_W),
        .BIG_ENDIAN (BIG_ENDIAN)
    ) u_wr_swap (
        .din  (bus_wdata),
        .size (bus_size),
        .dout (wr_swapped)
    );

    // inbound lanes follow the size held with the read strobe
    io_lane_swap #(
        .DATA_W     (DATA_W),
        .BIG_ENDIAN (BIG_ENDIAN)
    ) u_rd_swap (
        .din  (port_rdata),
        .size (q.port_size),
        .dout (rd_swapped)
    );

    assign accept = bus_req && win_hit && size_legal(bus_size);

    always_comb begin
        d         = q;
        d.port_wr = 1'b0;
        d.port_rd = 1'b0;
        d.miss    = 1'b0;
        d.rvalid  = q.port_rd;

        if (q.port_rd) begin
            d.rdata = rd_swapped;
        end

        if (accept) begin
            d.port_addr  = xl_addr;
            d.port_size  = bus_size;
            d.port_wdata = bus_we ? wr_swapped : '0;
            d.port_wr    = bus_we;
            d.port_rd    = !bus_we;
        end else if (bus_req) begin
            d.miss = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign bus_miss   = q.miss;
    assign bus_rvalid = q.rvalid;
    assign bus_rdata  = q.rdata;
    assign port_addr  = q.port_addr;
    assign port_size  = q.port_size;
    assign port_wdata = q.port_wdata;
    assign port_wr    = q.port_wr;
    assign port_rd    = q.port_rd;

endmodule

// File: rtl/io_window_xlate_chk.sv
module io_window_xlate_chk #(
    parameter int                ADDR_W     = 32,
    parameter int                DATA_W     = 32,
    parameter int                PORT_W     = 16,
    parameter int                WIN_BITS   = 23,
    parameter int                GROUP_BITS = 5,
    parameter int                PAGE_BIT   = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h8000_0000,
    parameter bit                BIG_ENDIAN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              map_sparse,
    input logic              bus_miss,
    input logic              bus_rvalid,
    input logic [PORT_W-1:0] port_addr,
    input logic [DATA_W-1:0] port_wdata,
    input logic              port_wr,
    input logic              port_rd
);

    logic in_win;
    logic good;

    assign in_win = (bus_addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);
    assign good   = bus_req && in_win && (bus_size != 2'd3);

    // R2
    hit_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        good |=> ((port_wr ^ port_rd) && !bus_miss));

    // R2
    out_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !in_win) |=> (bus_miss && !port_wr && !port_rd));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> (!port_wr && !port_rd && !bus_miss));

    // R9
    bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_size == 2'd3) |=> (bus_miss && !port_wr && !port_rd));

    // R2
    dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good && bus_we) |=> port_wr);

    // R3
    flat_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good && !map_sparse) |=> (port_addr == $past(bus_addr[PORT_W-1:0])));

    // R4
    sparse_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good && map_sparse) |=>
            (port_addr == PORT_W'({$past(bus_addr[WIN_BITS-1:PAGE_BIT]),
                                   $past(bus_addr[GROUP_BITS-1:0])})));

    // R5
    byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good && bus_we && bus_size == 2'd0) |=>
            (port_wdata == DATA_W'($past(bus_wdata[7:0]))));

    generate
        if (BIG_ENDIAN) begin : g_be_chk
            // R7
            word_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (good && bus_we && bus_size == 2'd2) |=>
                    (port_wdata == {$past(bus_wdata[7:0]),   $past(bus_wdata[15:8]),
                                    $past(bus_wdata[23:16]), $past(bus_wdata[31:24])}));
        end
    endgenerate

    // R8
    rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd |=> bus_rvalid);

    // R8
    rvalid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(port_rd));

    // R2
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({port_wr, port_rd, bus_miss}));

endmodule

bind io_window_xlate io_window_xlate_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PORT_W     (PORT_W),
    .WIN_BITS   (WIN_BITS),
    .GROUP_BITS (GROUP_BITS),
    .PAGE_BIT   (PAGE_BIT),
    .WIN_BASE   (WIN_BASE),
    .BIG_ENDIAN (BIG_ENDIAN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .map_sparse (map_sparse),
    .bus_miss   (bus_miss),
    .bus_rvalid (bus_rvalid),
    .port_addr  (port_addr),
    .port_wdata (port_wdata),
    .port_wr    (port_wr),
    .port_rd    (port_rd)
);

// File: tb/io_window_xlate_bench.sv
module io_window_xlate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        map_sparse = 1'b0;

    logic        bus_miss, bus_rvalid, port_wr, port_rd;
    logic [31:0] bus_rdata, port_wdata, port_rdata;
    logic [15:0] port_addr;
    logic [1:0]  port_size;

    logic        le_miss, le_rvalid, le_wr, le_rd;
    logic [31:0] le_rdata, le_wdata, le_port_rdata;
    logic [15:0] le_addr;
    logic [1:0]  le_size;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    function automatic logic [31:0] dev_data(input logic [15:0] a);
        return {a ^ 16'h5A3C, a};
    endfunction

    assign port_rdata    = port_rd ? dev_data(port_addr) : 32'h0;
    assign le_port_rdata = le_rd   ? dev_data(le_addr)   : 32'h0;

    io_window_xlate u_io_window_xlate (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .map_sparse(map_sparse), .bus_miss(bus_miss), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .port_addr(port_addr), .port_size(port_size),
        .port_wdata(port_wdata), .port_wr(port_wr), .port_rd(port_rd),
        .port_rdata(port_rdata)
    );

    io_window_xlate #(.BIG_ENDIAN(1'b0)) u_io_window_xlate_le (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .map_sparse(map_sparse), .bus_miss(le_miss), .bus_rvalid(le_rvalid),
        .bus_rdata(le_rdata), .port_addr(le_addr), .port_size(le_size),
        .port_wdata(le_wdata), .port_wr(le_wr), .port_rd(le_rd),
        .port_rdata(le_port_rdata)
    );

    typedef struct {
        logic        miss;
        logic        we;
        logic [15:0] addr;
        logic [1:0]  size;
        logic [31:0] w_be;
        logic [31:0] w_le;
        string       tag;
    } strobe_item_t;

    typedef struct {
        logic [31:0] r_be;
        logic [31:0] r_le;
        string       tag;
    } read_item_t;

    strobe_item_t sq[$];
    read_item_t   rq[$];

    function automatic logic [31:0] ref_swap(input logic [31:0] v, input logic [1:0] sz,
                                             input bit be);
        case (sz)
            2'd0:    return {24'h0, v[7:0]};
            2'd1:    return be ? {16'h0, v[7:0], v[15:8]} : {16'h0, v[15:0]};
            default: return be ? {v[7:0], v[15:8], v[23:16], v[31:24]} : v;
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] a, input logic [1:0] sz, input logic we,
                         input logic [31:0] wd, input logic sp, input string tag);
        strobe_item_t it;
        logic inwin;
        inwin     = (a[31:23] == 9'h100);
        it.miss   = !(inwin && sz != 2'd3);
        it.we     = we;
        it.addr   = sp ? {a[22:12], a[4:0]} : a[15:0];
        it.size   = sz;
        it.w_be   = ref_swap(wd, sz, 1'b1);
        it.w_le   = ref_swap(wd, sz, 1'b0);
        it.tag    = tag;
        sq.push_back(it);
        bus_req    = 1'b1;
        bus_addr   = a;
        bus_size   = sz;
        bus_we     = we;
        bus_wdata  = wd;
        map_sparse = sp;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        bus_req = 1'b0;
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // monitor: compare port activity and read returns against the queues
    always @(negedge clk) begin
        strobe_item_t it;
        read_item_t   ri;
        if (rst_n) begin
            if (port_wr || port_rd || bus_miss) begin
                if (sq.size() == 0) begin
                    chk("R2", "unexpected port activity", {port_wr, port_rd, bus_miss}, 32'h0);
                end else begin
                    it = sq.pop_front();
                    chk(it.tag, "miss", bus_miss, it.miss);
                    chk(it.tag, "le miss R10", le_miss, it.miss);
                    if (it.miss) begin
                        chk(it.tag, "no strobe on miss", {port_wr, port_rd}, 32'h0);
                    end else begin
                        chk(it.tag, "wr strobe", port_wr, it.we);
                        chk(it.tag, "rd strobe", port_rd, !it.we);
                        chk(it.tag, "port_addr", port_addr, it.addr);
                        chk("R11", "port_size", port_size, it.size);
                        chk(it.tag, "le wr strobe R10", le_wr, it.we);
                        chk(it.tag, "le port_addr R10", le_addr, it.addr);
                        if (it.we) begin
                            chk(it.tag, "port_wdata", port_wdata, it.w_be);
                            chk({it.tag, " R10"}, "le port_wdata", le_wdata, it.w_le);
                        end else begin
                            ri.r_be = ref_swap(dev_data(it.addr), it.size, 1'b1);
                            ri.r_le = ref_swap(dev_data(it.addr), it.size, 1'b0);
                            ri.tag  = it.tag;
                            rq.push_back(ri);
                        end
                    end
                end
            end else if (le_wr || le_rd || le_miss) begin
                chk("R10", "le unexpected port activity", {le_wr, le_rd, le_miss}, 32'h0);
            end
            if (bus_rvalid || le_rvalid) begin
                if (rq.size() == 0) begin
                    chk("R8", "unexpected rvalid", {bus_rvalid, le_rvalid}, 32'h0);
                end else begin
                    ri = rq.pop_front();
                    chk("R8", "rvalid", bus_rvalid, 1'b1);
                    chk({"R8 ", ri.tag}, "bus_rdata", bus_rdata, ri.r_be);
                    chk("R10", "le rvalid", le_rvalid, 1'b1);
                    chk("R10", "le bus_rdata", le_rdata, ri.r_le);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "wr/rd/miss/rvalid after reset",
            {port_wr, port_rd, bus_miss, bus_rvalid}, 32'h0);

        // flat writes of every size
        issue(32'h8000_0398, 2'd0, 1'b1, 32'hDEAD_BEEF, 1'b0, "R5 R3");
        idle(1);
        issue(32'h8000_1234, 2'd1, 1'b1, 32'hCAFE_A1B2, 1'b0, "R6 R3");
        idle(1);
        issue(32'h8001_FFF8, 2'd2, 1'b1, 32'h1122_3344, 1'b0, "R7 R3");
        idle(1);

        // flat reads of every size
        issue(32'h8000_0092, 2'd0, 1'b0, 32'h0, 1'b0, "R5 R8");
        idle(2);
        issue(32'h8000_0850, 2'd1, 1'b0, 32'h0, 1'b0, "R6 R8");
        idle(2);
        issue(32'h8000_ABCD, 2'd2, 1'b0, 32'h0, 1'b0, "R7 R8");
        idle(2);

        // sparse map, bits [11:5] set and then cleared
        issue(32'h8012_3FE5, 2'd2, 1'b1, 32'hA0B1_C2D3, 1'b1, "R4");
        issue(32'h8012_3005, 2'd2, 1'b1, 32'hA0B1_C2D3, 1'b1, "R4");
        issue(32'h807F_F7FF, 2'd1, 1'b0, 32'h0, 1'b1, "R4");
        idle(2);

        // window boundaries
        issue(32'h8000_0000, 2'd0, 1'b1, 32'h0000_0055, 1'b0, "R2");
        issue(32'h807F_FFFF, 2'd0, 1'b0, 32'h0, 1'b0, "R2");
        issue(32'h7FFF_FFFF, 2'd0, 1'b1, 32'h0000_0011, 1'b0, "R2");
        issue(32'h8080_0000, 2'd2, 1'b0, 32'h0, 1'b0, "R2");
        issue(32'h0000_0398, 2'd1, 1'b1, 32'h0000_2222, 1'b0, "R2");
        idle(2);

        // illegal size inside the window
        issue(32'h8000_0100, 2'd3, 1'b1, 32'h1234_5678, 1'b0, "R9");
        issue(32'h8000_0104, 2'd3, 1'b0, 32'h0, 1'b1, "R9");
        idle(2);

        // back-to-back reads of mixed sizes
        issue(32'h8000_0010, 2'd2, 1'b0, 32'h0, 1'b0, "R8");
        issue(32'h8000_0022, 2'd1, 1'b0, 32'h0, 1'b0, "R8");
        issue(32'h8000_0033, 2'd0, 1'b0, 32'h0, 1'b0, "R8");
        issue(32'h8000_0044, 2'd2, 1'b1, 32'h0102_0304, 1'b0, "R7");
        idle(4);

        chk("R2", "pending strobe items", sq.size(), 32'h0);
        chk("R8", "pending read items", rq.size(), 32'h0);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule